// File: doc/BRIEF.md
# Tagged Character FIFO Pair with DMA Request Generation

This block buffers characters between a parallel host port and a serial channel. Each direction has its own small first-in first-out store. Every receive entry holds a character together with status bits from the serial receiver. Every transmit entry holds a character together with command bits for the serial transmitter. The host can move up to four characters in a burst without waiting for the line.

Two active-low request pins serve a DMA controller. Their meaning depends on the selected DMA arrangement. In the shared-line arrangement, one pin covers both directions. In the split arrangement, each direction has its own pin. With DMA off, the pins are general-purpose outputs that the host sets.

A hold output tells the far end to pause while the receive store is full. Sticky flags report a character lost to a full receive store and a character requested from an empty transmit store.

Top module: `chan_fifo_dma`

## Requirements
- R1: After reset both stores are empty, `rx_valid_o`, `tx_valid_o`, `remote_hold_o` and `underrun_o` are 0, `tx_space_o` is 1, and both request pins are high.
- R2: The receive store holds 4 entries and returns characters with their status (`rx_stat_o` bits below the top bit) in arrival order. `rx_valid_o` is 1 while it holds any entry, and `rx_pop_i` removes the head.
- R3: The transmit store holds 4 entries and returns characters with their commands in host write order. `tx_space_o` is 1 while fewer than 4 entries are held, and `tx_pull_i` removes the head.
- R4: `remote_hold_o` is 1 exactly while the receive store holds 4 entries. It drops in the cycle after a pop frees an entry.
- R5: A receive push while the store is full and no pop is present discards the new character. It sets the overrun bit, the top bit of `rx_stat_o`, on the newest stored entry; older entries keep it clear. A push together with a pop while full is accepted normally.
- R6: `tx_pull_i` while the transmit store is empty sets `underrun_o`. The flag stays set until `underrun_clr_i`. When a set and a clear meet in the same cycle, the set wins.
- R7: A host push into a full transmit store is ignored. A pop or pull from an empty store leaves that store empty.
- R8: With `dma_mode_i` = 00 or 11 (DMA off), `req1_no` = NOT gpo[0] and `req2_no` = NOT gpo[1]. The 2-bit gpo register loads `gpo_val_i` when `gpo_wr_i` is 1 and keeps its value otherwise, in every mode.
- R9: With `dma_mode_i` = 01 (shared line), `req1_no` is low exactly when (`rx_en_i` and the receive store is non-empty) or (`tx_en_i` and the transmit store is not full). `req2_no` = NOT gpo[1].
- R10: With `dma_mode_i` = 10 (split lines), `req1_no` is low exactly when `rx_en_i` is 1 and the receive store is non-empty. `req2_no` is low exactly when `tx_en_i` is 1 and the transmit store is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | Serial side writes a received character |
| rx_char_i | input | 8 | Received character |
| rx_stat_i | input | 3 | Status bits for the received character |
| rx_pop_i | input | 1 | Host removes the receive head |
| rx_char_o | output | 8 | Receive head character |
| rx_stat_o | output | 4 | {overrun, status} of the receive head |
| rx_valid_o | output | 1 | Receive store non-empty |
| tx_push_i | input | 1 | Host writes a character to transmit |
| tx_char_i | input | 8 | Character to transmit |
| tx_cmd_i | input | 2 | Command bits for that character |
| tx_space_o | output | 1 | Transmit store not full |
| tx_pull_i | input | 1 | Serial side takes the transmit head |
| tx_char_o | output | 8 | Transmit head character |
| tx_cmd_o | output | 2 | Transmit head command bits |
| tx_valid_o | output | 1 | Transmit store non-empty |
| underrun_o | output | 1 | Sticky underrun flag |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| remote_hold_o | output | 1 | Asks the far sender to pause |
| rx_en_i | input | 1 | Receiver enabled |
| tx_en_i | input | 1 | Transmitter enabled |
| dma_mode_i | input | 2 | 00/11 off, 01 shared line, 10 split lines |
| gpo_wr_i | input | 1 | Loads the general-purpose bits |
| gpo_val_i | input | 2 | Value for the general-purpose bits |
| req1_no | output | 1 | Request pin 1, active low |
| req2_no | output | 1 | Request pin 2, active low |

## Verification
The request pins are hardest to cover from the ports. Their value depends on two fill levels, two enables, the mode and the stored general-purpose bits all at once. The stimulus therefore resets the block and fills the stores to every level from 0 to 4 in both directions. At each level pair it walks every mode, enable pair and gpo value, and compares both pins with a value computed in the bench. Overrun marking needs a full store plus one more push without a pop. The bench builds that case directly, then builds the push-with-pop case that must not flag.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;
  typedef enum logic [1:0] {
    DMA_OFF   = 2'b00,
    DMA_SHARE = 2'b01,
    DMA_SPLIT = 2'b10,
    DMA_OFF2  = 2'b11
  } dma_mode_e;
endpackage

// File: rtl/tag_fifo.sv
module tag_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  parameter bit MARK  = 1'b0,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          mark_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, last_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop, drop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || pop_i);
  assign drop    = push_i && full_o && !pop_i;
  assign last_ptr = (wr_ptr_q == '0) ? AW'(DEPTH - 1) : wr_ptr_q - 1'b1;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o = mem_q[rd_ptr_q];

  generate
    if (MARK) begin : g_mark
      logic [DEPTH-1:0] mk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mk_q <= '0;
        else begin
          if (do_push) mk_q[wr_ptr_q] <= 1'b0;
          if (drop)    mk_q[last_ptr] <= 1'b1;
        end
      end
      assign mark_o = mk_q[rd_ptr_q] && !empty_o;
    end else begin : g_nomark
      assign mark_o = 1'b0;
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> full_o && $stable(wr_ptr_q)); // R5
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o); // R7
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import chan_fifo_pkg::*;
#(
  parameter int GPO_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       dma_mode_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             rx_avail_i,
  input  logic             tx_room_i,
  input  logic             gpo_wr_i,
  input  logic [GPO_W-1:0] gpo_val_i,
  output logic             req1_no,
  output logic             req2_no
);
  logic [GPO_W-1:0] gpo_q;
  logic             rx_need, tx_need;
  dma_mode_e        mode;

  assign mode    = dma_mode_e'(dma_mode_i);
  assign rx_need = rx_en_i && rx_avail_i;
  assign tx_need = tx_en_i && tx_room_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gpo_q <= '0;
    else if (gpo_wr_i) gpo_q <= gpo_val_i;
  end

  always_comb begin
    unique case (mode)
      DMA_SHARE: begin
        req1_no = !(rx_need || tx_need);
        req2_no = !gpo_q[1];
      end
      DMA_SPLIT: begin
        req1_no = !rx_need;
        req2_no = !tx_need;
      end
      default: begin
        req1_no = !gpo_q[0];
        req2_no = !gpo_q[1];
      end
    endcase
  end

  AST_GPO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == DMA_OFF && !gpo_wr_i) |=> (dma_mode_i != DMA_OFF || $stable(req1_no))); // R8
endmodule

// File: rtl/chan_fifo_dma.sv
module chan_fifo_dma #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 3,
  parameter int CMD_W  = 2,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  logic [STAT_W-1:0] rx_stat_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_char_o,
  output logic [STAT_W:0]   rx_stat_o,
  output logic              rx_valid_o,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_char_i,
  input  logic [CMD_W-1:0]  tx_cmd_i,
  output logic              tx_space_o,
  input  logic              tx_pull_i,
  output logic [DATA_W-1:0] tx_char_o,
  output logic [CMD_W-1:0]  tx_cmd_o,
  output logic              tx_valid_o,
  output logic              underrun_o,
  input  logic              underrun_clr_i,
  output logic              remote_hold_o,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic [1:0]        dma_mode_i,
  input  logic              gpo_wr_i,
  input  logic [1:0]        gpo_val_i,
  output logic              req1_no,
  output logic              req2_no
);
  localparam int RXW = DATA_W + STAT_W;
  localparam int TXW = DATA_W + CMD_W;

  logic [RXW-1:0] rx_dout;
  logic [TXW-1:0] tx_dout;
  logic rx_empty, rx_full, rx_mark, tx_empty, tx_full, tx_mark_unused;
  logic undr_q;

  tag_fifo #(.W(RXW), .DEPTH(DEPTH), .MARK(1'b1)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push_i),
    .din_i  ({rx_stat_i, rx_char_i}),
    .pop_i  (rx_pop_i),
    .dout_o (rx_dout),
    .mark_o (rx_mark),
    .empty_o(rx_empty),
    .full_o (rx_full)
  );

  tag_fifo #(.W(TXW), .DEPTH(DEPTH), .MARK(1'b0)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push_i && !tx_full),
    .din_i  ({tx_cmd_i, tx_char_i}),
    .pop_i  (tx_pull_i),
    .dout_o (tx_dout),
    .mark_o (tx_mark_unused),
    .empty_o(tx_empty),
    .full_o (tx_full)
  );

  dma_req_gen #(.GPO_W(2)) u_dma_req (
    .clk_i, .rst_ni,
    .dma_mode_i,
    .rx_en_i,
    .tx_en_i,
    .rx_avail_i(!rx_empty),
    .tx_room_i (!tx_full),
    .gpo_wr_i,
    .gpo_val_i,
    .req1_no,
    .req2_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   undr_q <= 1'b0;
    else if (tx_pull_i && tx_empty) undr_q <= 1'b1;
    else if (underrun_clr_i)       undr_q <= 1'b0;
  end

  assign rx_char_o     = rx_dout[DATA_W-1:0];
  assign rx_stat_o     = {rx_mark, rx_dout[RXW-1:DATA_W]};
  assign rx_valid_o    = !rx_empty;
  assign tx_char_o     = tx_dout[DATA_W-1:0];
  assign tx_cmd_o      = tx_dout[TXW-1:DATA_W];
  assign tx_valid_o    = !tx_empty;
  assign tx_space_o    = !tx_full;
  assign remote_hold_o = rx_full;
  assign underrun_o    = undr_q;

  AST_UNDERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pull_i && !tx_valid_o) |=> underrun_o); // R6
  AST_UNDERRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !underrun_clr_i) |=> underrun_o); // R6
  AST_HOLD_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!remote_hold_o && !rx_push_i) |=> !remote_hold_o); // R4
endmodule

// File: tb/chan_fifo_dma_tb.sv
module chan_fifo_dma_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_push_i = 0, rx_pop_i = 0, tx_push_i = 0, tx_pull_i = 0;
  logic [7:0] rx_char_i = 0, tx_char_i = 0;
  logic [2:0] rx_stat_i = 0;
  logic [1:0] tx_cmd_i = 0;
  logic underrun_clr_i = 0, rx_en_i = 0, tx_en_i = 0, gpo_wr_i = 0;
  logic [1:0] dma_mode_i = 0, gpo_val_i = 0;
  logic [7:0] rx_char_o, tx_char_o;
  logic [3:0] rx_stat_o;
  logic [1:0] tx_cmd_o;
  logic rx_valid_o, tx_space_o, tx_valid_o, underrun_o, remote_hold_o, req1_no, req2_no;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  chan_fifo_dma u_dut (.*);

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; step(); rst_ni = 1'b1; step();
  endtask

  task automatic rx_put(input logic [7:0] c, input logic [2:0] s, input logic pop);
    rx_push_i = 1; rx_char_i = c; rx_stat_i = s; rx_pop_i = pop;
    step();
    rx_push_i = 0; rx_pop_i = 0;
  endtask

  task automatic tx_put(input logic [7:0] c, input logic [1:0] m);
    tx_push_i = 1; tx_char_i = c; tx_cmd_i = m;
    step();
    tx_push_i = 0;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_ni = 1'b1; step();
    // R1 reset state
    chk("R1 rx_valid", rx_valid_o, 0);
    chk("R1 tx_valid", tx_valid_o, 0);
    chk("R1 hold", remote_hold_o, 0);
    chk("R1 underrun", underrun_o, 0);
    chk("R1 tx_space", tx_space_o, 1);
    chk("R1 req1", req1_no, 1);
    chk("R1 req2", req2_no, 1);

    // R2 R4 R5: fill, overflow by one
    for (int k = 0; k < 5; k++) begin
      rx_put(8'(k * 37 + 5), 3'(k), 1'b0);
      if (k == 2) chk("R4 hold at 3", remote_hold_o, 0);
      if (k == 3) chk("R4 hold at 4", remote_hold_o, 1);
    end
    chk("R5 still full", remote_hold_o, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R2 rx valid", rx_valid_o, 1);
      chk("R2 rx char", rx_char_o, (k * 37 + 5) & 8'hff);
      chk("R5 rx stat ovr", rx_stat_o, ((k == 3) ? 8 : 0) + k);
      rx_pop_i = 1; step(); rx_pop_i = 0;
      if (k == 0) chk("R4 hold after pop", remote_hold_o, 0);
    end
    chk("R2 rx empty", rx_valid_o, 0);
    rx_pop_i = 1; step(); rx_pop_i = 0;
    chk("R7 rx pop empty", rx_valid_o, 0);

    // R5 push with pop while full is accepted
    for (int k = 0; k < 4; k++) rx_put(8'(k + 100), 3'(7 - k), 1'b0);
    rx_put(8'd104, 3'd3, 1'b1);
    for (int k = 1; k < 5; k++) begin
      chk("R5 pushpop char", rx_char_o, k + 100);
      chk("R5 pushpop stat", rx_stat_o, (k == 4) ? 3 : 7 - k);
      rx_pop_i = 1; step(); rx_pop_i = 0;
    end
    chk("R5 pushpop empty", rx_valid_o, 0);

    // R3 R7 transmit store
    for (int k = 0; k < 5; k++) begin
      tx_put(8'(k * 11 + 3), 2'(k));
      if (k == 2) chk("R3 space at 3", tx_space_o, 1);
      if (k == 3) chk("R3 space at 4", tx_space_o, 0);
    end
    for (int k = 0; k < 4; k++) begin
      chk("R3 tx char", tx_char_o, k * 11 + 3);
      chk("R3 tx cmd", tx_cmd_o, k & 3);
      tx_pull_i = 1; step(); tx_pull_i = 0;
    end
    chk("R7 full push dropped", tx_valid_o, 0);
    chk("R6 no underrun yet", underrun_o, 0);

    // R6 underrun
    tx_pull_i = 1; step(); tx_pull_i = 0;
    chk("R6 set", underrun_o, 1);
    chk("R7 tx pull empty", tx_valid_o, 0);
    step();
    chk("R6 sticky", underrun_o, 1);
    underrun_clr_i = 1; step(); underrun_clr_i = 0;
    chk("R6 cleared", underrun_o, 0);
    tx_pull_i = 1; underrun_clr_i = 1; step(); tx_pull_i = 0; underrun_clr_i = 0;
    chk("R6 set wins", underrun_o, 1);
    underrun_clr_i = 1; step(); underrun_clr_i = 0;
    chk("R6 clear again", underrun_o, 0);

    // R8 R9 R10 sweep over fill levels, modes, enables, gpo
    for (int rl = 0; rl <= 4; rl++) begin
      for (int tl = 0; tl <= 4; tl++) begin
        do_reset();
        for (int k = 0; k < rl; k++) rx_put(8'(k), 3'd0, 1'b0);
        for (int k = 0; k < tl; k++) tx_put(8'(k), 2'd0);
        for (int m = 0; m < 4; m++)
          for (int en = 0; en < 4; en++)
            for (int g = 0; g < 4; g++) begin
              bit rxa, txr;
              int e1, e2;
              dma_mode_i = 2'(m); rx_en_i = en[0]; tx_en_i = en[1];
              gpo_wr_i = 1; gpo_val_i = 2'(g);
              step();
              gpo_wr_i = 0;
              rxa = en[0] && (rl > 0);
              txr = en[1] && (tl < 4);
              if (m == 1) begin
                e1 = !(rxa || txr); e2 = !g[1];
                chk("R9 req1", req1_no, e1);
                chk("R9 req2", req2_no, e2);
              end else if (m == 2) begin
                e1 = !rxa; e2 = !txr;
                chk("R10 req1", req1_no, e1);
                chk("R10 req2", req2_no, e2);
              end else begin
                e1 = !g[0]; e2 = !g[1];
                chk("R8 req1", req1_no, e1);
                chk("R8 req2", req2_no, e2);
              end
            end
        // gpo retained without write
        dma_mode_i = 2'd0; step();
        chk("R8 gpo retained req1", req1_no, 0);
        chk("R8 gpo retained req2", req2_no, 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule